// File: doc/BRIEF.md
# Safety-Armed Control Command Executor

This block carries out control commands that an upstream decoder has already extracted from incoming traffic. Each command arrives as a one-cycle request with a 4-bit opcode and a small selector field. The block holds a CPU reset level and a bank of external signal levels, and presents both to a downstream command interface. It also emits one-cycle reset pulses toward the link channels, either to a single selected channel or to all of them at once.

Commands that can disturb the system are classed as safety-critical: the CPU reset commands and the link reset commands. None of them runs unless a one-shot arming register has first been set by a dedicated arm command. Executing any safety-critical command clears that register again. Any request the block will not execute gets a one-cycle reject pulse, and it changes no output and no internal state.

All outputs are registered. A request sampled on one rising edge shows its effect on the outputs right after that same edge.

Top module: `ctl_cmd_exec`

## Requirements
- R1: After reset, cpu_rst_o is 0, ext_sig_o is all zeros, link_rst_o is all zeros, cmd_rej_o is 0, and the arming register is disarmed.
- R2: Opcode 1 (arm) is never rejected. It sets the arming register, so the next safety-critical command executes.
- R3: A safety-critical command received while disarmed is rejected. cmd_rej_o pulses for one cycle and no output changes.
- R4: Executing a safety-critical command disarms the block, so a second safety-critical command that is not preceded by a new arm is rejected.
- R5: Opcode 2 drives cpu_rst_o to 1 and opcode 3 drives it to 0. Both opcodes are safety-critical, and the level holds between commands.
- R6: Opcode 4 sets ext_sig_o[sel] and opcode 5 clears it. These opcodes are not safety-critical, they leave the arming register unchanged, and the levels hold between commands.
- R7: Opcode 6 (safety-critical) drives link_rst_o[sel] high for exactly one cycle.
- R8: Opcode 7 (safety-critical) drives every bit of link_rst_o high for exactly one cycle.
- R9: Opcodes 0 and 8–15, and opcode 6 with sel ≥ NUM_LINKS, are rejected. They leave the arming register unchanged.
- R10: An arm command received while already armed leaves the block armed, and only one safety-critical command then executes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | One-cycle command request |
| cmd_op_i | input | 4 | Command opcode |
| cmd_sel_i | input | SEL_W | Link or signal index |
| cpu_rst_o | output | 1 | CPU reset level |
| ext_sig_o | output | NUM_SIGS | External signal levels |
| link_rst_o | output | NUM_LINKS | Per-link reset pulses |
| cmd_rej_o | output | 1 | One-cycle reject pulse |

## Verification
The arming register cannot be seen directly, so any fault in it shows up one cycle after the next safety-critical request. If the register is wrongly clear, the request gets a reject pulse. If it is wrongly set, cpu_rst_o or link_rst_o changes when it should not. The bench therefore issues safety-critical commands right after arming, right after an execution, after a double arm, and after rejected commands. A faulty selector decode or a stuck pulse shows up on the very next sampled cycle as a wrong bit in ext_sig_o or link_rst_o.

// File: rtl/ctl_cmd_pkg.sv
package ctl_cmd_pkg;

  typedef enum logic [3:0] {
    OP_ARM      = 4'd1,
    OP_CPU_ON   = 4'd2,
    OP_CPU_OFF  = 4'd3,
    OP_SIG_ON   = 4'd4,
    OP_SIG_OFF  = 4'd5,
    OP_LINK_ONE = 4'd6,
    OP_LINK_ALL = 4'd7
  } cmd_op_e;

  typedef struct packed {
    logic known;
    logic safety;
    logic arm;
    logic cpu_on;
    logic cpu_off;
    logic sig_on;
    logic sig_off;
    logic link_one;
    logic link_all;
  } cmd_class_t;

endpackage

// File: rtl/ctl_cmd_decode.sv
module ctl_cmd_decode
  import ctl_cmd_pkg::*;
#(
  parameter int NUM_LINKS = 3,
  parameter int NUM_SIGS  = 4,
  parameter int SEL_W     = 2
) (
  input  logic [3:0]       op_i,
  input  logic [SEL_W-1:0] sel_i,
  output cmd_class_t       cls_o,
  output logic             sel_ok_o
);

  always_comb begin
    cls_o = '0;
    unique case (op_i)
      OP_ARM:      begin cls_o.known = 1'b1; cls_o.arm = 1'b1; end
      OP_CPU_ON:   begin cls_o.known = 1'b1; cls_o.safety = 1'b1; cls_o.cpu_on = 1'b1; end
      OP_CPU_OFF:  begin cls_o.known = 1'b1; cls_o.safety = 1'b1; cls_o.cpu_off = 1'b1; end
      OP_SIG_ON:   begin cls_o.known = 1'b1; cls_o.sig_on = 1'b1; end
      OP_SIG_OFF:  begin cls_o.known = 1'b1; cls_o.sig_off = 1'b1; end
      OP_LINK_ONE: begin cls_o.known = 1'b1; cls_o.safety = 1'b1; cls_o.link_one = 1'b1; end
      OP_LINK_ALL: begin cls_o.known = 1'b1; cls_o.safety = 1'b1; cls_o.link_all = 1'b1; end
      default:     cls_o = '0;
    endcase
  end

  // selector range only matters for indexed commands
  always_comb begin
    sel_ok_o = 1'b1;
    if (cls_o.link_one) sel_ok_o = (int'(sel_i) < NUM_LINKS);
    else if (cls_o.sig_on || cls_o.sig_off) sel_ok_o = (int'(sel_i) < NUM_SIGS);
  end

endmodule

// File: rtl/ctl_cmd_arm.sv
module ctl_cmd_arm
  import ctl_cmd_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       valid_i,
  input  cmd_class_t cls_i,
  input  logic       sel_ok_i,
  output logic       exec_o,
  output logic       armed_o,
  output logic       rej_o
);

  logic armed_q, rej_q, exec_safe;

  assign exec_o    = valid_i && cls_i.known && sel_ok_i && (!cls_i.safety || armed_q);
  assign exec_safe = exec_o && cls_i.safety;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      rej_q   <= 1'b0;
    end else begin
      rej_q <= valid_i && !exec_o;
      if (valid_i && cls_i.arm) armed_q <= 1'b1;
      else if (exec_safe)       armed_q <= 1'b0;
    end
  end

  assign armed_o = armed_q;
  assign rej_o   = rej_q;

  assert_disarm_after_exec_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_safe |=> !armed_q);

  assert_arm_sets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cls_i.arm) |=> (armed_q && !rej_q));

endmodule

// File: rtl/ctl_cmd_drive.sv
module ctl_cmd_drive
  import ctl_cmd_pkg::*;
#(
  parameter int NUM_LINKS = 3,
  parameter int NUM_SIGS  = 4,
  parameter int SEL_W     = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 exec_i,
  input  logic                 armed_i,
  input  cmd_class_t           cls_i,
  input  logic [SEL_W-1:0]     sel_i,
  output logic                 cpu_rst_o,
  output logic [NUM_SIGS-1:0]  ext_sig_o,
  output logic [NUM_LINKS-1:0] link_rst_o
);

  logic cpu_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cpu_q <= 1'b0;
    else if (exec_i && cls_i.cpu_on)  cpu_q <= 1'b1;
    else if (exec_i && cls_i.cpu_off) cpu_q <= 1'b0;
  end
  assign cpu_rst_o = cpu_q;

  for (genvar g = 0; g < NUM_SIGS; g++) begin : g_sig
    logic hit, lvl_q;
    assign hit = exec_i && (sel_i == SEL_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                   lvl_q <= 1'b0;
      else if (hit && cls_i.sig_on)  lvl_q <= 1'b1;
      else if (hit && cls_i.sig_off) lvl_q <= 1'b0;
    end
    assign ext_sig_o[g] = lvl_q;
  end

  for (genvar g = 0; g < NUM_LINKS; g++) begin : g_link
    logic pulse_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pulse_q <= 1'b0;
      else pulse_q <= exec_i && (cls_i.link_all || (cls_i.link_one && sel_i == SEL_W'(g)));
    end
    assign link_rst_o[g] = pulse_q;
  end

  assert_cpu_needs_arm_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(cpu_rst_o) || $fell(cpu_rst_o)) |-> $past(armed_i));

  assert_link_single_cycle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_rst_o != '0) |=> (link_rst_o == '0));

  assert_link_shape_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(link_rst_o) || (link_rst_o == '1));

  assert_sig_one_bit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(ext_sig_o ^ $past(ext_sig_o)) <= 1);

endmodule

// File: rtl/ctl_cmd_exec.sv
module ctl_cmd_exec
  import ctl_cmd_pkg::*;
#(
  parameter  int NUM_LINKS = 3,
  parameter  int NUM_SIGS  = 4,
  localparam int SEL_MAX   = (NUM_LINKS > NUM_SIGS) ? NUM_LINKS : NUM_SIGS,
  localparam int SEL_W     = (SEL_MAX > 1) ? $clog2(SEL_MAX) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cmd_valid_i,
  input  logic [3:0]           cmd_op_i,
  input  logic [SEL_W-1:0]     cmd_sel_i,
  output logic                 cpu_rst_o,
  output logic [NUM_SIGS-1:0]  ext_sig_o,
  output logic [NUM_LINKS-1:0] link_rst_o,
  output logic                 cmd_rej_o
);

  cmd_class_t cls;
  logic sel_ok, exec, armed;

  ctl_cmd_decode #(.NUM_LINKS(NUM_LINKS), .NUM_SIGS(NUM_SIGS), .SEL_W(SEL_W)) u_dec (
    .op_i(cmd_op_i), .sel_i(cmd_sel_i), .cls_o(cls), .sel_ok_o(sel_ok)
  );

  ctl_cmd_arm u_arm (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(cmd_valid_i), .cls_i(cls),
    .sel_ok_i(sel_ok), .exec_o(exec), .armed_o(armed), .rej_o(cmd_rej_o)
  );

  ctl_cmd_drive #(.NUM_LINKS(NUM_LINKS), .NUM_SIGS(NUM_SIGS), .SEL_W(SEL_W)) u_drv (
    .clk_i(clk_i), .rst_ni(rst_ni), .exec_i(exec), .armed_i(armed), .cls_i(cls),
    .sel_i(cmd_sel_i), .cpu_rst_o(cpu_rst_o), .ext_sig_o(ext_sig_o), .link_rst_o(link_rst_o)
  );

  // a rejected request leaves every level untouched (R3, R9)
  assert_rej_no_effect_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_rej_o |-> ($stable(cpu_rst_o) && $stable(ext_sig_o) && link_rst_o == '0));

endmodule

// File: tb/ctl_cmd_exec_test.sv
`timescale 1ns/1ps
module ctl_cmd_exec_test;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [3:0] cmd_op = '0;
  logic [1:0] cmd_sel = '0;
  logic       cpu_rst;
  logic [3:0] ext_sig;
  logic [2:0] link_rst;
  logic       cmd_rej;

  always #2 clk = ~clk;  // 250 MHz

  ctl_cmd_exec uut (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .cmd_sel_i(cmd_sel), .cpu_rst_o(cpu_rst), .ext_sig_o(ext_sig),
    .link_rst_o(link_rst), .cmd_rej_o(cmd_rej)
  );

  typedef struct {
    logic       cpu;
    logic [3:0] sig;
    logic [2:0] link;
    logic       rej;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   n_run = 0, n_fail = 0;
  bit   done = 0;

  logic       m_cpu = 0;
  logic [3:0] m_sig = '0;
  bit         m_armed = 0;

  task automatic push_item(logic [2:0] lk, logic rj, string tag);
    exp_t e;
    e.cpu = m_cpu; e.sig = m_sig; e.link = lk; e.rej = rj; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic send(logic [3:0] op, logic [1:0] sel, string tag);
    bit known, safety, selok, ex;
    logic [2:0] lk;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_sel = sel;
    known  = (op >= 4'd1 && op <= 4'd7);
    safety = (op == 4'd2 || op == 4'd3 || op == 4'd6 || op == 4'd7);
    selok  = !(op == 4'd6 && sel >= 2'd3);
    ex     = known && selok && (!safety || m_armed);
    lk     = '0;
    if (ex) begin
      case (op)
        4'd2: m_cpu = 1'b1;
        4'd3: m_cpu = 1'b0;
        4'd4: m_sig[sel] = 1'b1;
        4'd5: m_sig[sel] = 1'b0;
        4'd6: lk[sel] = 1'b1;
        4'd7: lk = 3'b111;
        default: ;
      endcase
    end
    if (op == 4'd1) m_armed = 1;
    else if (ex && safety) m_armed = 0;
    push_item(lk, !ex, tag);
  endtask

  task automatic idle(string tag);
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = '0; cmd_sel = '0;
    push_item(3'b000, 1'b0, tag);
  endtask

  // monitor: compare one expected item per cycle, away from the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_run++;
        if (cpu_rst !== e.cpu || ext_sig !== e.sig || link_rst !== e.link || cmd_rej !== e.rej) begin
          n_fail++;
          $display("FAIL %s: got cpu=%b sig=%b link=%b rej=%b, exp cpu=%b sig=%b link=%b rej=%b",
                   e.tag, cpu_rst, ext_sig, link_rst, cmd_rej, e.cpu, e.sig, e.link, e.rej);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    n_run++;
    if (cpu_rst !== 1'b0 || ext_sig !== 4'b0 || link_rst !== 3'b0 || cmd_rej !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: got cpu=%b sig=%b link=%b rej=%b, exp all zero", cpu_rst, ext_sig, link_rst, cmd_rej);
    end
    send(4'd2, 2'd0, "R1 disarmed after reset");
    send(4'd6, 2'd1, "R3 link reset while disarmed");
    send(4'd4, 2'd2, "R6 set sig 2");
    send(4'd4, 2'd0, "R6 set sig 0");
    send(4'd5, 2'd2, "R6 clear sig 2");
    idle("R6 hold");
    send(4'd1, 2'd0, "R2 arm");
    send(4'd2, 2'd0, "R5 cpu reset on");
    send(4'd2, 2'd0, "R4 second safety rejected");
    send(4'd1, 2'd0, "R10 arm once");
    send(4'd1, 2'd0, "R10 arm twice");
    send(4'd4, 2'd3, "R6 sig keeps arming");
    send(4'd6, 2'd1, "R7 link 1 pulse");
    idle("R7 pulse ends");
    send(4'd6, 2'd0, "R4 link after disarm");
    send(4'd1, 2'd0, "R2 arm");
    send(4'd6, 2'd3, "R9 link sel out of range");
    send(4'd6, 2'd0, "R9 arming kept, link 0");
    send(4'd9, 2'd0, "R9 unknown opcode 9");
    send(4'd0, 2'd0, "R9 unknown opcode 0");
    send(4'd1, 2'd0, "R2 arm");
    send(4'd15, 2'd1, "R9 unknown keeps arming");
    send(4'd7, 2'd0, "R8 all links pulse");
    idle("R8 pulse ends");
    send(4'd7, 2'd0, "R4 all links after disarm");
    send(4'd1, 2'd0, "R2 arm");
    send(4'd3, 2'd0, "R5 cpu reset off");
    send(4'd3, 2'd0, "R3 cpu off while disarmed");
    send(4'd5, 2'd0, "R6 clear sig 0");
    idle("R6 final hold");
    idle("final");
    while (q.size() > 0) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog (R1..R10 sequence hung): got timeout, exp completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule